// File: doc/BRIEF.md
# Return-to-Zero Inverted Infrared Pulse Codec

This block sits between a bit-serial framer and the optical front end of a medium-speed infrared link. On the transmit side it pulls one bit per bit period from the framer with a request strobe. It drives the LED output with a short light pulse for every zero bit and keeps the LED dark for every one bit. The pulse lasts one quarter of the bit period. The framer decides the bit order. For byte data that order is least significant bit first, and the codec keeps whatever order it is given.

On the receive side the photodiode input is first synchronised. It is then sampled sixteen times per bit period by a clock enable from the same divider. A window counter splits the samples into bit windows. A window holding at least two consecutive lit samples decodes as zero, and any other window decodes as one. Each detected pulse moves the window so that the window starts at the pulse's first lit sample. This tracks drift between the two ends of the link. A rate select input picks one of two divider ratios, and the slow ratio is twice the fast one. These ratios correspond to the two line rates of 0.576 and 1.152 Mb/s. One enable input gates both directions.

Top module: `rzi_codec`

## Requirements
- R1: While `en_i` is low, and after reset, `led_o` is dark and `bit_req_o` and `rx_vld_o` stay low. Dropping `en_i` darkens `led_o` by the next clock edge.
- R2: A bit value 0 taken from `tx_bit_i` produces exactly one light pulse on `led_o`. A bit value 1 produces none.
- R3: Each light pulse lasts 4 samples, one quarter of the 16-sample bit period. That is 4×DIV clocks.
- R4: `bit_req_o` pulses for one clock once every 16 samples. `tx_bit_i` is taken in that clock, and the pulse for that bit starts with the new bit period.
- R5: `rate_i` = 0 selects DIV_SLOW clocks per sample and `rate_i` = 1 selects DIV_FAST clocks per sample. With the defaults these are 4 and 2, so the slow bit period is twice the fast one.
- R6: After lock, each receive window emits one bit on `rx_bit_o` with a one-clock `rx_vld_o`. The bit is 0 if the window held at least 2 consecutive lit samples, and 1 otherwise. An isolated single lit sample therefore decodes as 1.
- R7: The receiver emits no bits until it detects its first pulse (2 or more consecutive lit samples). Single-sample glitches do not lock it. Lock is lost when `en_i` is low.
- R8: Each detected pulse realigns the receive window to its first lit sample. A pulse that lands in the second half of a window first closes that window and emits its bit. Pulse trains spaced 14 or 17 samples apart therefore decode one zero per pulse.
- R9: With `led_o` looped back to `pd_i`, a bit sequence decodes in the same order it was sent, starting with the first zero bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Enables transmit and receive; low forces idle |
| rate_i | input | 1 | 0: slow rate, 1: fast rate (twice the slow) |
| tx_bit_i | input | 1 | Next bit to send, taken when bit_req_o is high |
| bit_req_o | output | 1 | One-clock strobe per bit period asking for the next bit |
| led_o | output | 1 | LED drive, high means light |
| pd_i | input | 1 | Asynchronous photodiode input, high means light |
| rx_bit_o | output | 1 | Recovered bit, valid with rx_vld_o |
| rx_vld_o | output | 1 | One-clock strobe per recovered bit |

## Verification
A wrong sample phase or divider count in the transmitter shows up on `led_o` within one bit period, as a pulse or request spacing other than 4 or 16 samples. A stuck bit register shows up as a wrong pulse count per byte. In the receiver, a window that is not realigned takes several pulses to show, because drift builds up by one or two samples per bit. For that reason the drift trains run for twenty pulses, which is long enough to push a fixed window across a boundary and change the number of zeros decoded. A bad lock or decision threshold shows within one window, as an extra or missing `rx_vld_o` or a flipped `rx_bit_o`.

// File: rtl/rzi_pkg.sv
package rzi_pkg;
  typedef enum logic {
    RATE_SLOW = 1'b0,
    RATE_FAST = 1'b1
  } rate_e;
endpackage

// File: rtl/rzi_sync.sv
module rzi_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] s_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= d_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= {s_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = s_q[STAGES-1];
endmodule

// File: rtl/rzi_tick_gen.sv
module rzi_tick_gen
  import rzi_pkg::*;
#(
  parameter int DIV_SLOW = 4,
  parameter int DIV_FAST = 2
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  en_i,
  input  rate_e rate_i,
  output logic  tick_o
);
  localparam int DMAX = (DIV_SLOW > DIV_FAST) ? DIV_SLOW : DIV_FAST;
  localparam int CW   = $clog2(DMAX + 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] lim;
  logic          tick_q;

  assign lim = (rate_i == RATE_FAST) ? CW'(DIV_FAST - 1) : CW'(DIV_SLOW - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else if (!en_i) begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      tick_q <= (cnt_q >= lim);
      cnt_q  <= (cnt_q >= lim) ? '0 : cnt_q + 1'b1;
    end
  end

  assign tick_o = tick_q;

  assert_tick_gap_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o);
endmodule

// File: rtl/rzi_tx.sv
module rzi_tx #(
  parameter int SPB     = 16,
  parameter int PULSE   = 4,
  parameter int LIT_MAX = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic tick_i,
  input  logic tx_bit_i,
  output logic bit_req_o,
  output logic led_o
);
  localparam int PW = $clog2(SPB);
  localparam int LW = $clog2(LIT_MAX + 2);

  logic [PW-1:0] ph_q;
  logic          cur_q;
  logic          led_q;

  assign bit_req_o = en_i & tick_i & (ph_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q  <= '0;
      cur_q <= 1'b1;
      led_q <= 1'b0;
    end else if (!en_i) begin
      ph_q  <= '0;
      cur_q <= 1'b1;
      led_q <= 1'b0;
    end else if (tick_i) begin
      ph_q <= (ph_q == PW'(SPB - 1)) ? '0 : ph_q + 1'b1;
      if (ph_q == '0) begin
        cur_q <= tx_bit_i;
        led_q <= ~tx_bit_i;      // zero bit: light
      end else if (ph_q < PW'(PULSE)) begin
        led_q <= ~cur_q;
      end else begin
        led_q <= 1'b0;
      end
    end
  end

  assign led_o = led_q;

  // checker: consecutive lit clocks
  logic [LW-1:0] lit_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  lit_q <= '0;
    else if (!led_o)              lit_q <= '0;
    else if (lit_q <= LW'(LIT_MAX)) lit_q <= lit_q + 1'b1;
  end

  assert_dark_off_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !led_o);
  assert_req_loads_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_req_o |=> (led_o == !$past(tx_bit_i)));
  assert_pulse_bound_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lit_q <= LW'(LIT_MAX));
  assert_req_single_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_req_o |=> !bit_req_o);
endmodule

// File: rtl/rzi_rx.sv
module rzi_rx #(
  parameter int SPB     = 16,
  parameter int MIN_RUN = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic tick_i,
  input  logic lit_i,
  output logic bit_o,
  output logic bit_vld_o
);
  localparam int PW   = $clog2(SPB);
  localparam int RW   = $clog2(MIN_RUN + 1);
  localparam int HALF = SPB / 2;

  logic [PW-1:0] wph_q;
  logic [RW-1:0] run_q;
  logic          hit_q, lock_q, bit_q, vld_q;
  logic          det;

  // pulse detected on the sample that completes the minimum run
  assign det = tick_i & lit_i & (run_q == RW'(MIN_RUN - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wph_q  <= '0;
      run_q  <= '0;
      hit_q  <= 1'b0;
      lock_q <= 1'b0;
      bit_q  <= 1'b1;
      vld_q  <= 1'b0;
    end else if (!en_i) begin
      wph_q  <= '0;
      run_q  <= '0;
      hit_q  <= 1'b0;
      lock_q <= 1'b0;
      bit_q  <= 1'b1;
      vld_q  <= 1'b0;
    end else begin
      vld_q <= 1'b0;
      if (tick_i) begin
        if (!lit_i)                         run_q <= '0;
        else if (run_q != RW'(MIN_RUN))     run_q <= run_q + 1'b1;

        if (det) begin
          // early pulse closes the running window first
          if (lock_q && wph_q >= PW'(HALF)) begin
            vld_q <= 1'b1;
            bit_q <= ~hit_q;
          end
          lock_q <= 1'b1;
          hit_q  <= 1'b1;
          wph_q  <= PW'(MIN_RUN);
        end else if (wph_q == PW'(SPB - 1)) begin
          wph_q <= '0;
          hit_q <= 1'b0;
          if (lock_q) begin
            vld_q <= 1'b1;
            bit_q <= ~hit_q;
          end
        end else begin
          wph_q <= wph_q + 1'b1;
        end
      end
    end
  end

  assign bit_o     = bit_q;
  assign bit_vld_o = vld_q;

  assert_no_bit_unlocked_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lock_q |=> !bit_vld_o);
  assert_one_per_window_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_vld_o |=> !bit_vld_o);
  assert_quiet_off_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !bit_vld_o);
endmodule

// File: rtl/rzi_codec.sv
module rzi_codec #(
  parameter int SAMPLES_PER_BIT = 16,
  parameter int DIV_SLOW        = 4,
  parameter int DIV_FAST        = 2,
  parameter int MIN_RUN         = 2,
  parameter int SYNC_STAGES     = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic rate_i,
  input  logic tx_bit_i,
  output logic bit_req_o,
  output logic led_o,
  input  logic pd_i,
  output logic rx_bit_o,
  output logic rx_vld_o
);
  localparam int PULSE   = SAMPLES_PER_BIT / 4;
  localparam int DMAX    = (DIV_SLOW > DIV_FAST) ? DIV_SLOW : DIV_FAST;
  localparam int LIT_MAX = PULSE * DMAX;

  logic tick;
  logic pd_s;

  rzi_tick_gen #(.DIV_SLOW(DIV_SLOW), .DIV_FAST(DIV_FAST)) u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en_i),
    .rate_i (rzi_pkg::rate_e'(rate_i)),
    .tick_o (tick)
  );

  rzi_tx #(.SPB(SAMPLES_PER_BIT), .PULSE(PULSE), .LIT_MAX(LIT_MAX)) u_tx (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (en_i),
    .tick_i    (tick),
    .tx_bit_i  (tx_bit_i),
    .bit_req_o (bit_req_o),
    .led_o     (led_o)
  );

  rzi_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (pd_i),
    .q_o    (pd_s)
  );

  rzi_rx #(.SPB(SAMPLES_PER_BIT), .MIN_RUN(MIN_RUN)) u_rx (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (en_i),
    .tick_i    (tick),
    .lit_i     (pd_s),
    .bit_o     (rx_bit_o),
    .bit_vld_o (rx_vld_o)
  );
endmodule

// File: tb/rzi_codec_test.sv
`timescale 1ns/1ps
module rzi_codec_test;
  localparam int SPB   = 16;
  localparam int DS    = 4;
  localparam int DF    = 2;
  localparam int PULSE = 4;
  localparam int NVEC  = 6;
  // {rate, data byte}
  localparam logic [8:0] VEC [NVEC] = '{
    {1'b0, 8'hA5}, {1'b1, 8'h3C}, {1'b0, 8'h00},
    {1'b1, 8'hFF}, {1'b1, 8'h4B}, {1'b0, 8'h81}
  };

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n = 1'b0, en = 1'b0, rate = 1'b0, tx_bit = 1'b1;
  logic man_rx = 1'b0, loop_sel = 1'b0, mon_clr = 1'b0;
  logic req, led, rx_bit, rx_vld, pd;

  assign pd = loop_sel ? led : man_rx;

  rzi_codec #(.SAMPLES_PER_BIT(SPB), .DIV_SLOW(DS), .DIV_FAST(DF)) uut (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .rate_i(rate), .tx_bit_i(tx_bit),
    .bit_req_o(req), .led_o(led), .pd_i(pd), .rx_bit_o(rx_bit), .rx_vld_o(rx_vld)
  );

  int checks = 0, errors = 0;
  int hi_cnt, pulses, wmin, wmax, gap, smin, smax, nrx, nreq;
  bit req_seen, led_prev;
  bit rxbits [64];

  always @(negedge clk) begin
    if (mon_clr) begin
      hi_cnt = 0; pulses = 0; wmin = 1000000; wmax = 0; gap = 0;
      smin = 1000000; smax = 0; nrx = 0; nreq = 0; req_seen = 0;
    end else begin
      gap++;
      if (led) hi_cnt++;
      if (led && !led_prev) pulses++;
      if (!led && led_prev) begin
        if (hi_cnt < wmin) wmin = hi_cnt;
        if (hi_cnt > wmax) wmax = hi_cnt;
        hi_cnt = 0;
      end
      if (req) begin
        nreq++;
        if (req_seen) begin
          if (gap < smin) smin = gap;
          if (gap > smax) smax = gap;
        end
        req_seen = 1; gap = 0;
      end
      if (rx_vld) begin
        if (nrx < 64) rxbits[nrx] = rx_bit;
        nrx++;
      end
    end
    led_prev = led;
  end

  task automatic report();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic chk(input bit ok, input string req_tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req_tag, act, exp);
    end
  endtask

  task automatic clear_mon();
    @(posedge clk) mon_clr = 1'b1;
    @(posedge clk) mon_clr = 1'b0;
  endtask

  task automatic feed_one(input int len, input int spacing);
    man_rx = 1'b1;
    repeat (len * DF) @(negedge clk);
    man_rx = 1'b0;
    repeat ((spacing - len) * DF) @(negedge clk);
  endtask

  task automatic run_vector(input logic r, input logic [7:0] d);
    int div, zeros, got;
    div = r ? DF : DS;
    loop_sel = 1'b1;
    @(negedge clk) en = 1'b0; rate = r; tx_bit = 1'b0;
    clear_mon();
    @(negedge clk) en = 1'b1;
    for (int k = 0; k < 10; k++) begin
      do @(negedge clk); while (!req);
      @(posedge clk);
      #1 tx_bit = (k < 8) ? d[k] : 1'b1;
    end
    repeat (3 * SPB * div) @(negedge clk);
    zeros = 8 - $countones(d);
    chk(pulses == 1 + zeros, "R2 pulse count", pulses, 1 + zeros);
    chk(wmin == PULSE * div && wmax == PULSE * div, "R3 pulse width", wmax, PULSE * div);
    chk(smin == SPB * div && smax == SPB * div, r ? "R5 fast period" : "R4 slow period",
        smax, SPB * div);
    chk(nrx >= 9, "R9 bit count", nrx, 9);
    got = 0;
    for (int i = 0; i < 8; i++) got[i] = rxbits[i + 1];
    chk(rxbits[0] == 1'b0 && got == int'(d), "R9 loopback byte", got, d);
    zeros = 0;
    for (int i = 9; i < nrx && i < 64; i++) if (!rxbits[i]) zeros++;
    chk(zeros == 0, "R6 dark windows decode 1", zeros, 0);
    @(negedge clk) en = 1'b0;
  endtask

  task automatic drift_test(input int spacing, input int n);
    int zeros;
    loop_sel = 1'b0;
    @(negedge clk) en = 1'b0; rate = 1'b1;
    clear_mon();
    @(negedge clk) en = 1'b1;
    repeat (5 * DF) @(negedge clk);
    for (int i = 0; i < n; i++) feed_one(PULSE, spacing);
    repeat (20 * DF) @(negedge clk);
    zeros = 0;
    for (int i = 0; i < n && i < nrx; i++) if (!rxbits[i]) zeros++;
    chk(nrx >= n && zeros == n, "R8 drift tracking", zeros, n);
    @(negedge clk) en = 1'b0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    bit exp_bits [6];
    int mism;
    // R1: reset state
    repeat (3) @(negedge clk);
    chk(led == 1'b0 && req == 1'b0 && rx_vld == 1'b0, "R1 reset outputs",
        {led, req, rx_vld}, 0);
    rst_n = 1'b1;
    clear_mon();
    for (int i = 0; i < 6; i++) feed_one(PULSE, SPB);
    chk(pulses == 0 && nreq == 0, "R1 idle tx while disabled", pulses + nreq, 0);
    chk(nrx == 0, "R1 no rx while disabled", nrx, 0);

    // table-driven loopback
    for (int v = 0; v < NVEC; v++) run_vector(VEC[v][8], VEC[v][7:0]);

    // R7: glitches do not lock, then decision pattern (R6)
    loop_sel = 1'b0;
    @(negedge clk) rate = 1'b1;
    clear_mon();
    @(negedge clk) en = 1'b1;
    for (int i = 0; i < 6; i++) feed_one(1, SPB);
    chk(nrx == 0, "R7 glitches keep unlocked", nrx, 0);
    feed_one(4, SPB); feed_one(1, SPB); feed_one(2, SPB);
    feed_one(0, SPB); feed_one(3, SPB); feed_one(1, SPB);
    repeat (4 * DF) @(negedge clk);
    exp_bits = '{1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1};
    chk(nrx >= 6, "R7 lock then emit", nrx, 6);
    mism = 0;
    for (int i = 0; i < 6; i++) if (rxbits[i] != exp_bits[i]) mism++;
    chk(mism == 0, "R6 run-length decision", mism, 0);
    @(negedge clk) en = 1'b0;

    // R8: late and early pulse trains
    drift_test(17, 20);
    drift_test(14, 20);

    // R1: disable mid-pulse
    loop_sel = 1'b1; tx_bit = 1'b0;
    @(negedge clk) rate = 1'b0; en = 1'b1;
    do @(negedge clk); while (!led);
    en = 1'b0;
    @(negedge clk);
    chk(led == 1'b0 && req == 1'b0, "R1 dark after disable", led, 0);
    clear_mon();
    repeat (100) @(negedge clk);
    chk(nrx == 0 && pulses == 0, "R1 silent after disable", nrx + pulses, 0);

    report();
  end
endmodule